// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers the interrupt sources of a small 8-bit controller and turns them into one request line and a 13-bit vector address for the CPU core. There are six sources. The power-on reset ranks highest. Next come a counter input pin and three timer events. The external interrupt pin ranks lowest. Each maskable source has a request flag and an enable flag, and both sit in two byte-wide control registers. Software sets the enables. Software clears a request flag by writing 0 to it.

The CPU drives a global disable input, which comes from its interrupt-mask flag. This input silences every maskable source, but it has no effect on the reset. A software break request shares the lowest vector slot with the external pin, and the disable input does not stop it. When the CPU raises its acknowledge, the controller captures the winning vector address and keeps it until the next acknowledge. It also retires the reset or break condition if that condition was the winner.

The two pins are asynchronous and active low. Each pin passes through a two-flop synchroniser, and a falling edge on it sets its request flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00, `irqOut` is 1 because the reset source is pending, and `vecAddr` is 0x1FFE.
- R2: Register A (`regSel`=0) has the following bit layout. Bit 7 is the count-pin request and bit 6 its enable. Bit 5 is the Timer 1 request and bit 4 its enable. Bit 3 is the Timer 2 request and bit 2 its enable. Bit 1 is the external-pin request and bit 0 its enable. In register B (`regSel`=1), bit 7 is the Timer X request and bit 6 its enable. Bits 5 and 3..0 are plain read/write storage. Bit 4 always reads 0.
- R3: A source event sets its request bit. A register write of 0 to a request bit clears it, and a write of 1 leaves it unchanged. If an event and a clearing write hit the same bit in the same cycle, the bit ends set. Enable bits take the written value.
- R4: A falling edge on `cntPinN` or `extPinN` sets its request bit on the third rising clock edge after the pin changes. A pin that stays low, or a rising edge, sets nothing.
- R5: `irqOut` is 1 exactly when one of three conditions holds: reset is pending; some source has both its request and enable bits set while `globalDis`=0; or a break is pending.
- R6: The vector addresses are 0x1FFE for reset, 0x1FFC for the count pin, 0x1FFA for Timer X, 0x1FF8 for Timer 1, 0x1FF6 for Timer 2, and 0x1FF4 for the external pin or break. When several sources are pending at once, the one with the higher address wins.
- R7: `globalDis`=1 masks every source except reset and break. Reset stays pending and still wins.
- R8: A `brkReq` pulse makes a break pending, and it vectors to 0x1FF4 even when `globalDis`=1. An acknowledge that selects slot 0x1FF4 retires the pending break.
- R9: The winning vector is loaded into `vecAddr` at the rising edge where `ackIn`=1 and `irqOut`=1, and is visible after that edge. At every other edge `vecAddr` holds its value. An acknowledge that selects reset retires the reset condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; also makes the reset source pending |
| regSel | input | 1 | Register select: 0 = register A, 1 = register B |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Current contents of the selected register |
| cntPinN | input | 1 | Asynchronous count pin, falling-edge source |
| extPinN | input | 1 | Asynchronous external interrupt pin, falling-edge source |
| tmrXEvt | input | 1 | Timer X underflow pulse |
| tmr1Evt | input | 1 | Timer 1 underflow pulse |
| tmr2Evt | input | 1 | Timer 2 underflow pulse |
| brkReq | input | 1 | Software break request pulse |
| globalDis | input | 1 | CPU interrupt-disable flag |
| irqOut | output | 1 | Interrupt request to the CPU |
| vecAddr | output | 13 | Latched vector address |
| ackIn | input | 1 | CPU acknowledge |

## Verification
The hardest cases to reach involve collisions in the same cycle. One is a clearing write landing on the same edge as a source event. Another is a break request arriving on the same edge as an acknowledge that retires an older break. A third is an acknowledge arriving while both the external pin and a break hold the shared lowest slot. The stimulus reaches these in two ways. Directed sequences line up the event, the write and the acknowledge on a single edge. A long random phase then toggles pins, events, writes, disable and acknowledge at independent rates, and a behavioural model checks every output on every clock.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_SRC = 6;

  // index order is priority order: lower index wins
  typedef enum logic [2:0] {
    SRC_RESET = 3'd0,
    SRC_CNT   = 3'd1,
    SRC_TMRX  = 3'd2,
    SRC_TMR1  = 3'd3,
    SRC_TMR2  = 3'd4,
    SRC_LOW   = 3'd5
  } srcSel_e;

  typedef struct packed {
    logic    loadVec;
    srcSel_e winSel;
    logic    clrRst;
    logic    clrBrk;
  } ctlStrobe_t;

  // request positions in register A (enable sits one bit below)
  localparam int A_CNT_REQ  = 7;
  localparam int A_TMR1_REQ = 5;
  localparam int A_TMR2_REQ = 3;
  localparam int A_EXT_REQ  = 1;
  localparam logic [7:0] A_REQ_MASK = 8'hAA;
endpackage

// File: rtl/prio_irq_dp.sv
module prio_irq_dp
  import prio_irq_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] VEC_TOP = 13'h1FFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              cntPinN,
  input  logic              extPinN,
  input  logic              tmrXEvt,
  input  logic              tmr1Evt,
  input  logic              tmr2Evt,
  input  logic              brkReq,
  input  ctlStrobe_t        strobe,
  output logic [7:0]        regA,
  output logic [7:0]        regB,
  output logic              rstPend,
  output logic              brkPend,
  output logic [ADDR_W-1:0] vecAddr
);
  localparam int NUM_PINS = 2;
  localparam int CHAIN_W  = SYNC_STAGES + 1;

  logic [NUM_PINS-1:0] pinRaw;
  logic [NUM_PINS-1:0] pinFall;

  assign pinRaw = {extPinN, cntPinN};

  // synchroniser plus one history flop per pin
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [CHAIN_W-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chain <= '1;
      end else begin
        chain <= {chain[CHAIN_W-2:0], pinRaw[p]};
      end
    end
    assign pinFall[p] = !chain[SYNC_STAGES-1] && chain[SYNC_STAGES];
  end

  logic       wrA, wrB;
  logic [7:0] setA;
  logic [7:0] nextA, nextB;

  assign wrA = regWrEn && !regSel;
  assign wrB = regWrEn && regSel;

  always_comb begin
    setA = '0;
    setA[A_CNT_REQ]  = pinFall[0];
    setA[A_TMR1_REQ] = tmr1Evt;
    setA[A_TMR2_REQ] = tmr2Evt;
    setA[A_EXT_REQ]  = pinFall[1];
  end

  always_comb begin
    nextA = regA;
    if (wrA) begin
      nextA = (regA & regWrData & A_REQ_MASK) | (regWrData & ~A_REQ_MASK);
    end
    nextA = nextA | setA;
  end

  always_comb begin
    nextB = regB;
    if (wrB) begin
      nextB = {regB[7] & regWrData[7], regWrData[6:5], 1'b0, regWrData[3:0]};
    end
    nextB[7] = nextB[7] | tmrXEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA    <= '0;
      regB    <= '0;
      rstPend <= 1'b1;
      brkPend <= 1'b0;
      vecAddr <= VEC_TOP;
    end else begin
      regA    <= nextA;
      regB    <= nextB;
      rstPend <= rstPend && !strobe.clrRst;
      brkPend <= (brkPend && !strobe.clrBrk) || brkReq;
      if (strobe.loadVec) begin
        vecAddr <= VEC_TOP - (ADDR_W'(strobe.winSel) << 1);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
  import prio_irq_pkg::*;
(
  input  logic [7:0] regA,
  input  logic       tmrxReq,
  input  logic       tmrxEn,
  input  logic       rstPend,
  input  logic       brkPend,
  input  logic       globalDis,
  input  logic       ackIn,
  output logic       irqOut,
  output ctlStrobe_t strobe
);
  logic [NUM_SRC-1:0] pend;
  logic               maskOk;
  srcSel_e            win;

  assign maskOk = !globalDis;

  always_comb begin
    pend = '0;
    pend[SRC_RESET] = rstPend;
    pend[SRC_CNT]   = maskOk && regA[A_CNT_REQ]  && regA[A_CNT_REQ-1];
    pend[SRC_TMRX]  = maskOk && tmrxReq && tmrxEn;
    pend[SRC_TMR1]  = maskOk && regA[A_TMR1_REQ] && regA[A_TMR1_REQ-1];
    pend[SRC_TMR2]  = maskOk && regA[A_TMR2_REQ] && regA[A_TMR2_REQ-1];
    pend[SRC_LOW]   = (maskOk && regA[A_EXT_REQ] && regA[A_EXT_REQ-1]) || brkPend;
  end

  always_comb begin
    win = SRC_LOW;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) win = srcSel_e'(i[2:0]);
    end
  end

  assign irqOut = |pend;

  always_comb begin
    strobe.loadVec = ackIn && irqOut;
    strobe.winSel  = win;
    strobe.clrRst  = strobe.loadVec && (win == SRC_RESET);
    strobe.clrBrk  = strobe.loadVec && (win == SRC_LOW) && brkPend;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] VEC_TOP = 13'h1FFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              cntPinN,
  input  logic              extPinN,
  input  logic              tmrXEvt,
  input  logic              tmr1Evt,
  input  logic              tmr2Evt,
  input  logic              brkReq,
  input  logic              globalDis,
  output logic              irqOut,
  output logic [ADDR_W-1:0] vecAddr,
  input  logic              ackIn
);
  logic [7:0] regA, regB;
  logic       rstPend, brkPend;
  ctlStrobe_t strobe;

  prio_irq_dp #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .VEC_TOP(VEC_TOP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .cntPinN(cntPinN), .extPinN(extPinN),
    .tmrXEvt(tmrXEvt), .tmr1Evt(tmr1Evt), .tmr2Evt(tmr2Evt),
    .brkReq(brkReq), .strobe(strobe), .regA(regA), .regB(regB),
    .rstPend(rstPend), .brkPend(brkPend), .vecAddr(vecAddr)
  );

  prio_irq_ctl u_ctl (
    .regA(regA), .tmrxReq(regB[7]), .tmrxEn(regB[6]),
    .rstPend(rstPend), .brkPend(brkPend), .globalDis(globalDis),
    .ackIn(ackIn), .irqOut(irqOut), .strobe(strobe)
  );

  assign regRdData = regSel ? regB : regA;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              regSel,
  input logic [7:0]        regRdData,
  input logic [7:0]        regA,
  input logic              tmr1Evt,
  input logic              brkReq,
  input logic              globalDis,
  input logic              irqOut,
  input logic              ackIn,
  input logic [ADDR_W-1:0] vecAddr
);
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ackIn && irqOut) |=> $stable(vecAddr)); // R9

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut) |=> (vecAddr[0] == 1'b0 && vecAddr >= 13'h1FF4)); // R6

  AST_DIS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut && globalDis) |=> (vecAddr == 13'h1FFE || vecAddr == 13'h1FF4)); // R7

  AST_BRK_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |=> irqOut); // R8

  AST_NO_SPURIOUS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !tmr1Evt |=> !$rose(regA[5])); // R3

  AST_UNUSED_BIT: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> !regRdData[4]); // R2
endmodule

bind prio_irq_ctrl prio_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regRdData(regRdData),
  .regA(regA), .tmr1Evt(tmr1Evt), .brkReq(brkReq), .globalDis(globalDis),
  .irqOut(irqOut), .ackIn(ackIn), .vecAddr(vecAddr)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0, regSel = 1'b0, regWrEn = 1'b0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic        cntPinN = 1'b1, extPinN = 1'b1;
  logic        tmrXEvt = 1'b0, tmr1Evt = 1'b0, tmr2Evt = 1'b0, brkReq = 1'b0;
  logic        globalDis = 1'b0, ackIn = 1'b0;
  logic        irqOut;
  logic [12:0] vecAddr;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .cntPinN(cntPinN),
    .extPinN(extPinN), .tmrXEvt(tmrXEvt), .tmr1Evt(tmr1Evt),
    .tmr2Evt(tmr2Evt), .brkReq(brkReq), .globalDis(globalDis),
    .irqOut(irqOut), .vecAddr(vecAddr), .ackIn(ackIn)
  );

  int total = 0, bad = 0;
  bit cmpOn = 0, finished = 0;

  // behavioural reference state
  int mA = 0, mB = 0, mVec = 'h1FFE;
  bit mRst = 1, mBrk = 0;
  int cntHist[$] = '{1, 1, 1};
  int extHist[$] = '{1, 1, 1};

  function automatic int modelWin();
    if (mRst) return 'h1FFE;
    if (!globalDis) begin
      if (mA[7] && mA[6]) return 'h1FFC;
      if (mB[7] && mB[6]) return 'h1FFA;
      if (mA[5] && mA[4]) return 'h1FF8;
      if (mA[3] && mA[2]) return 'h1FF6;
      if (mA[1] && mA[0]) return 'h1FF4;
    end
    if (mBrk) return 'h1FF4;
    return 0;
  endfunction

  always @(posedge clk) begin
    int w;
    bit cf, ef;
    if (!rstN) begin
      mA = 0; mB = 0; mVec = 'h1FFE; mRst = 1; mBrk = 0;
      cntHist = '{1, 1, 1};
      extHist = '{1, 1, 1};
    end else begin
      w  = modelWin();
      cf = (cntHist[1] == 0) && (cntHist[0] == 1);
      ef = (extHist[1] == 0) && (extHist[0] == 1);
      if (ackIn && w != 0) begin
        mVec = w;
        if (w == 'h1FFE) mRst = 0;
        else if (w == 'h1FF4 && mBrk) mBrk = 0;
      end
      if (brkReq) mBrk = 1;
      if (regWrEn && !regSel) mA = (mA & regWrData & 'hAA) | (regWrData & 'h55);
      if (regWrEn && regSel)  mB = ((mB & regWrData & 'h80) | (regWrData & 'h6F));
      if (cf) mA = mA | 'h80;
      if (tmr1Evt) mA = mA | 'h20;
      if (tmr2Evt) mA = mA | 'h08;
      if (ef) mA = mA | 'h02;
      if (tmrXEvt) mB = mB | 'h80;
      void'(cntHist.pop_front());
      cntHist.push_back(int'(cntPinN));
      void'(extHist.pop_front());
      extHist.push_back(int'(extPinN));
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (cmpOn) begin
      chk(int'(irqOut), int'(modelWin() != 0), "R5 irqOut");
      chk(int'(vecAddr), mVec, "R9 vecAddr");
      chk(int'(regRdData), regSel ? mB : mA, "R3 regRdData");
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1; cmpOn = 1;
    // R1 reset state
    chk(int'(regRdData), 'h00, "R1 regA");
    chk(int'(irqOut), 1, "R1 irq");
    chk(int'(vecAddr), 'h1FFE, "R1 vec");
    regSel = 1'b1; #1;
    chk(int'(regRdData), 'h00, "R1 regB");
    regSel = 1'b0;
    ackIn = 1; tick(); ackIn = 0;
    chk(int'(irqOut), 0, "R9 reset retired");
    // R2 / R3 layout and write-one behaviour
    regWrEn = 1; regSel = 0; regWrData = 8'hFF; tick();
    regSel = 1; tick();
    regWrEn = 0; regSel = 0; #1;
    chk(int'(regRdData), 'h55, "R3 write-one keeps requests");
    regSel = 1; #1;
    chk(int'(regRdData), 'h6F, "R2 regB bit map");
    regSel = 0;
    ackIn = 1; tick(); ackIn = 0;
    chk(int'(vecAddr), 'h1FFE, "R9 ack without irq");
    // R6 priority
    tmr2Evt = 1; tick(); tmr2Evt = 0;
    chk(int'(irqOut), 1, "R5 timer2 pending");
    ackIn = 1; tick(); ackIn = 0;
    chk(int'(vecAddr), 'h1FF6, "R6 timer2 vector");
    tmr1Evt = 1; tmrXEvt = 1; tick(); tmr1Evt = 0; tmrXEvt = 0;
    ackIn = 1; tick(); ackIn = 0;
    chk(int'(vecAddr), 'h1FFA, "R6 timerX over timer1");
    regSel = 1; regWrEn = 1; regWrData = 8'h6F; tick(); regWrEn = 0; regSel = 0;
    ackIn = 1; tick(); ackIn = 0;
    chk(int'(vecAddr), 'h1FF8, "R6 timer1 over timer2");
    // R3 event beats clearing write
    regWrEn = 1; regWrData = 8'h55; tmr1Evt = 1; tick(); regWrEn = 0; tmr1Evt = 0; #1;
    chk(int'(regRdData), 'h75, "R3 event wins over clear");
    regWrEn = 1; regWrData = 8'h55; tick(); regWrEn = 0;
    // R4 edge timing
    extPinN = 0; tick(); tick();
    chk(int'(regRdData), 'h55, "R4 not yet after two edges");
    tick();
    chk(int'(regRdData), 'h57, "R4 set on third edge");
    regWrEn = 1; regWrData = 8'h55; tick(); regWrEn = 0;
    repeat (4) tick();
    chk(int'(regRdData), 'h55, "R4 steady low sets nothing");
    extPinN = 1; repeat (4) tick();
    chk(int'(regRdData), 'h55, "R4 rising edge sets nothing");
    // R7 / R8 disable and break
    tmr2Evt = 1; tick(); tmr2Evt = 0;
    globalDis = 1; #1;
    chk(int'(irqOut), 0, "R7 disable masks");
    brkReq = 1; tick(); brkReq = 0;
    chk(int'(irqOut), 1, "R8 break under disable");
    ackIn = 1; tick(); ackIn = 0;
    chk(int'(vecAddr), 'h1FF4, "R8 break vector");
    chk(int'(irqOut), 0, "R8 break retired");
    globalDis = 0; #1;
    chk(int'(irqOut), 1, "R7 unmask restores");
    globalDis = 1; rstN = 0; tick(); rstN = 1;
    chk(int'(irqOut), 1, "R7 reset not masked");
    ackIn = 1; tick(); ackIn = 0;
    chk(int'(vecAddr), 'h1FFE, "R7 reset vector under disable");
    globalDis = 0;
    // random phase
    for (int i = 0; i < 600; i++) begin
      globalDis = ($urandom % 4) == 0;
      ackIn     = ($urandom % 5) == 0;
      regWrEn   = ($urandom % 4) == 0;
      regSel    = $urandom % 2;
      regWrData = 8'($urandom);
      tmrXEvt   = ($urandom % 8) == 0;
      tmr1Evt   = ($urandom % 8) == 0;
      tmr2Evt   = ($urandom % 8) == 0;
      brkReq    = ($urandom % 16) == 0;
      if (($urandom % 6) == 0) cntPinN = ~cntPinN;
      if (($urandom % 6) == 0) extPinN = ~extPinN;
      tick();
    end
    ackIn = 0; regWrEn = 0; tmrXEvt = 0; tmr1Evt = 0; tmr2Evt = 0; brkReq = 0;
    tick();
    finish();
  end
endmodule